// File: doc/BRIEF.md
# Banked GPIO port register file

This block is the register store of a byte-addressed general-purpose I/O expander. Lines are grouped into 8-line ports. Four banks (pad input, output value, input polarity inversion and line direction) each hold one byte per port. A bank starts at a multiple of a power-of-two stride, so a port count that is not a power of two leaves unused addresses between banks. A separate extension window at `EXT_BASE` holds the electrical settings for each line: drive strength, pull enable, pull direction and the push-pull/open-drain choice.

A simple single-cycle bus reaches every register. A write takes effect at the clock edge that samples it. Read data is registered and stays on `bus_rdata` until the next read. Pad inputs reach the input bank through a two-flop synchroniser. The block resolves, for each line, the output enable and output value for the pad ring. Drive strength and pull settings are stored bits, passed straight out to the pads.

Top module: `gpx_regfile`

## Requirements
- R1: After reset, every output and direction bit reads 1, and every invert, open-drain and pull bit reads 0. Every drive-strength field reads 11. `pad_oe` is all zero and `bus_rdata` is 0x00.
- R2: With S the smallest power of two that is at least `NUM_PORTS`, the register for port p of bank b sits at address b*S+p. The banks are 0=input, 1=output, 2=invert, 3=direction. With the default 3 ports they occupy 0x00–0x02, 0x04–0x06, 0x08–0x0A and 0x0C–0x0E.
- R3: A read of an address that decodes to no register returns 0x00. A write to such an address changes no stored state.
- R4: A read of input register p returns the pad byte of port p XOR invert register p. The pad byte is the value sampled through two flops. A write to the input bank is ignored.
- R5: A direction bit of 1 makes the line an input, with `pad_oe` low and `pad_out` low. A direction bit of 0 makes it an output.
- R6: An output line in push-pull mode drives `pad_oe`=1 and `pad_out` equal to its output bit.
- R7: The open-drain mode of a line is bit p of the port-mode byte at `EXT_BASE`+5*S (1=open-drain) XOR the line's bit in its override register at `EXT_BASE`+4*S+p. An open-drain output with output bit 0 drives `pad_oe`=1 and `pad_out`=0. With output bit 1 it releases the line (`pad_oe`=0).
- R8: Drive strength uses 2 bits per line: 00=0.25x, 01=0.50x, 10=0.75x, 11=1.00x. Port p keeps lines 0–3 at `EXT_BASE`+p and lines 4–7 at `EXT_BASE`+S+p, with the line with the lower number in the lower bit pair. Line i appears on `drv_str[2i+1:2i]`.
- R9: Pull-enable registers at `EXT_BASE`+2*S+p and pull-direction registers at `EXT_BASE`+3*S+p (1=up, 0=down) appear bit for bit on `pull_en` and `pull_up`.
- R10: Read data appears on `bus_rdata` after the edge that samples the read. It holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8*NUM_PORTS | Raw pad input levels |
| pad_oe | output | 8*NUM_PORTS | Per-line output enable |
| pad_out | output | 8*NUM_PORTS | Per-line driven value |
| drv_str | output | 16*NUM_PORTS | Drive-strength code, 2 bits per line |
| pull_en | output | 8*NUM_PORTS | Pull resistor enable per line |
| pull_up | output | 8*NUM_PORTS | Pull direction per line, 1 = up |

## Verification
A pad transition can reach the second synchroniser flop at the same edge that samples a read of the input bank. The read must then return the value held before that edge. The bench provokes this with frequent random pad changes interleaved with input-bank reads. A behavioural model that keeps its own two-stage pad history judges each returned byte. Writes to the port-mode byte and to per-line overrides also land in cycles when an output register changes. The resolved enables are compared against the model on every clock.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // Register class selected by the address decoder
    typedef enum logic [3:0] {
        SEL_HOLE,
        SEL_IN,
        SEL_OUT,
        SEL_INV,
        SEL_DIR,
        SEL_DRV_LO,
        SEL_DRV_HI,
        SEL_PULL_EN,
        SEL_PULL_UP,
        SEL_OD_LINE,
        SEL_OD_PORT
    } reg_sel_e;

    // Smallest power of two not below the port count
    function automatic int bank_stride(input int ports);
        int s;
        s = 1;
        for (int k = 0; k < 5; k++) begin
            if (s < ports) s = s * 2;
        end
        return s;
    endfunction

endpackage

// File: rtl/gpx_sync2.sv
module gpx_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/gpx_addr_decode.sv
module gpx_addr_decode
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 8,
    parameter int EXT_BASE  = 64,
    parameter int PORT_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [PORT_W-1:0] port
);
    localparam int STRIDE = bank_stride(NUM_PORTS);
    localparam int SH     = $clog2(STRIDE);
    localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(STRIDE - 1);
    localparam logic [ADDR_W-1:0] NP_A     = ADDR_W'(NUM_PORTS);
    localparam logic [ADDR_W-1:0] EXT_A    = ADDR_W'(EXT_BASE);

    logic [ADDR_W-1:0] core_bank_d, core_idx_d, ext_off_d, ext_bank_d, ext_idx_d;
    logic              core_hi_zero_d, ext_hi_zero_d;

    always_comb begin
        core_bank_d    = addr >> SH;
        core_idx_d     = addr & IDX_MASK;
        ext_off_d      = addr - EXT_A;
        ext_bank_d     = ext_off_d >> SH;
        ext_idx_d      = ext_off_d & IDX_MASK;
        core_hi_zero_d = (core_bank_d >> 2) == '0;
        ext_hi_zero_d  = (ext_bank_d >> 3) == '0;
        sel            = SEL_HOLE;
        port           = '0;

        if (addr < EXT_A) begin
            if (core_hi_zero_d && (core_idx_d < NP_A)) begin
                port = core_idx_d[PORT_W-1:0];
                case (core_bank_d[1:0])
                    2'd0:    sel = SEL_IN;
                    2'd1:    sel = SEL_OUT;
                    2'd2:    sel = SEL_INV;
                    default: sel = SEL_DIR;
                endcase
            end
        end else if (ext_hi_zero_d) begin
            if (ext_bank_d[2:0] == 3'd5) begin
                if (ext_idx_d == '0) sel = SEL_OD_PORT;
            end else if (ext_idx_d < NP_A) begin
                port = ext_idx_d[PORT_W-1:0];
                case (ext_bank_d[2:0])
                    3'd0:    sel = SEL_DRV_LO;
                    3'd1:    sel = SEL_DRV_HI;
                    3'd2:    sel = SEL_PULL_EN;
                    3'd3:    sel = SEL_PULL_UP;
                    3'd4:    sel = SEL_OD_LINE;
                    default: sel = SEL_HOLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpx_pad_ctrl.sv
module gpx_pad_ctrl #(
    parameter int NUM_PORTS = 3,
    parameter int LINES     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINES-1:0]     out_val,
    input  logic [LINES-1:0]     dir_in,
    input  logic [LINES-1:0]     od_flip,
    input  logic [NUM_PORTS-1:0] od_port,
    output logic [LINES-1:0]     oe,
    output logic [LINES-1:0]     dout
);
    logic [LINES-1:0] od_mode_d;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam int P = i / 8;

        always_comb begin
            od_mode_d[i] = od_port[P] ^ od_flip[i];
            oe[i]        = !dir_in[i] && (!od_mode_d[i] || !out_val[i]);
            dout[i]      = !dir_in[i] && !od_mode_d[i] && out_val[i];
        end

        AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
            dir_in[i] |-> (!oe[i] && !dout[i])); // R5
        AST_PUSH_PULL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (!dir_in[i] && !od_mode_d[i]) |-> (oe[i] && (dout[i] == out_val[i]))); // R6
        AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            od_mode_d[i] |-> !dout[i]); // R7
    end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 8,
    parameter int EXT_BASE  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    input  logic [8*NUM_PORTS-1:0]   pad_in,
    output logic [8*NUM_PORTS-1:0]   pad_oe,
    output logic [8*NUM_PORTS-1:0]   pad_out,
    output logic [16*NUM_PORTS-1:0]  drv_str,
    output logic [8*NUM_PORTS-1:0]   pull_en,
    output logic [8*NUM_PORTS-1:0]   pull_up
);
    localparam int LINES  = 8 * NUM_PORTS;
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    typedef struct packed {
        logic [LINES-1:0]     outv;
        logic [LINES-1:0]     inv;
        logic [LINES-1:0]     dir;
        logic [LINES-1:0]     od_flip;
        logic [LINES-1:0]     pen;
        logic [LINES-1:0]     pup;
        logic [2*LINES-1:0]   drv;
        logic [NUM_PORTS-1:0] od_port;
        logic [7:0]           rdata;
    } regs_t;

    regs_t               r_d, r_q;
    reg_sel_e            sel;
    logic [PORT_W-1:0]   port;
    logic [LINES-1:0]    pad_sync;
    logic [PORT_W+2:0]   lb_d;
    logic [PORT_W+3:0]   db_d;
    logic [7:0]          rd_d;
    logic [7:0]          odp_byte_d;
    logic                rd_req, wr_req;

    gpx_sync2 #(.W(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pad_sync)
    );

    gpx_addr_decode #(
        .NUM_PORTS(NUM_PORTS),
        .ADDR_W   (ADDR_W),
        .EXT_BASE (EXT_BASE),
        .PORT_W   (PORT_W)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel),
        .port(port)
    );

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    always_comb begin
        lb_d       = {port, 3'b000};
        db_d       = {port, 4'b0000};
        odp_byte_d = '0;
        odp_byte_d[NUM_PORTS-1:0] = r_q.od_port;

        rd_d = '0;
        case (sel)
            SEL_IN:      rd_d = pad_sync[lb_d +: 8] ^ r_q.inv[lb_d +: 8];
            SEL_OUT:     rd_d = r_q.outv[lb_d +: 8];
            SEL_INV:     rd_d = r_q.inv[lb_d +: 8];
            SEL_DIR:     rd_d = r_q.dir[lb_d +: 8];
            SEL_DRV_LO:  rd_d = r_q.drv[db_d +: 8];
            SEL_DRV_HI:  rd_d = r_q.drv[(db_d + 8) +: 8];
            SEL_PULL_EN: rd_d = r_q.pen[lb_d +: 8];
            SEL_PULL_UP: rd_d = r_q.pup[lb_d +: 8];
            SEL_OD_LINE: rd_d = r_q.od_flip[lb_d +: 8];
            SEL_OD_PORT: rd_d = odp_byte_d;
            default:     rd_d = '0;
        endcase

        r_d = r_q;
        if (rd_req) r_d.rdata = rd_d;
        if (wr_req) begin
            case (sel)
                SEL_OUT:     r_d.outv[lb_d +: 8]       = bus_wdata;
                SEL_INV:     r_d.inv[lb_d +: 8]        = bus_wdata;
                SEL_DIR:     r_d.dir[lb_d +: 8]        = bus_wdata;
                SEL_DRV_LO:  r_d.drv[db_d +: 8]        = bus_wdata;
                SEL_DRV_HI:  r_d.drv[(db_d + 8) +: 8]  = bus_wdata;
                SEL_PULL_EN: r_d.pen[lb_d +: 8]        = bus_wdata;
                SEL_PULL_UP: r_d.pup[lb_d +: 8]        = bus_wdata;
                SEL_OD_LINE: r_d.od_flip[lb_d +: 8]    = bus_wdata;
                SEL_OD_PORT: r_d.od_port               = bus_wdata[NUM_PORTS-1:0];
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.outv    <= '1;
            r_q.inv     <= '0;
            r_q.dir     <= '1;
            r_q.od_flip <= '0;
            r_q.pen     <= '0;
            r_q.pup     <= '0;
            r_q.drv     <= '1;
            r_q.od_port <= '0;
            r_q.rdata   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    gpx_pad_ctrl #(
        .NUM_PORTS(NUM_PORTS),
        .LINES    (LINES)
    ) u_pad (
        .clk    (clk),
        .rst_n  (rst_n),
        .out_val(r_q.outv),
        .dir_in (r_q.dir),
        .od_flip(r_q.od_flip),
        .od_port(r_q.od_port),
        .oe     (pad_oe),
        .dout   (pad_out)
    );

    assign bus_rdata = r_q.rdata;
    assign drv_str   = r_q.drv;
    assign pull_en   = r_q.pen;
    assign pull_up   = r_q.pup;

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata)); // R10
    AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_HOLE) |=> (bus_rdata == 8'h00)); // R3
    AST_HOLE_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_HOLE) |=> ($stable(pad_oe) && $stable(pad_out)
            && $stable(drv_str) && $stable(pull_en) && $stable(pull_up))); // R3
    AST_INPUT_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel == SEL_IN) |=> ($stable(pad_oe) && $stable(pad_out)
            && $stable(drv_str))); // R4
endmodule

// File: tb/sim_gpx_regfile.sv
module sim_gpx_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NP    = 3;
    localparam int LINES = 8 * NP;
    localparam int S     = (NP <= 1) ? 1 : (NP <= 2) ? 2 : (NP <= 4) ? 4 : 8;
    localparam int EXT   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [LINES-1:0]  pad_in = '0;
    logic [LINES-1:0]  pad_oe, pad_out, pull_en, pull_up;
    logic [2*LINES-1:0] drv_str;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [7:0] m_out [NP];
    logic [7:0] m_inv [NP];
    logic [7:0] m_dir [NP];
    logic [7:0] m_dlo [NP];
    logic [7:0] m_dhi [NP];
    logic [7:0] m_pen [NP];
    logic [7:0] m_pup [NP];
    logic [7:0] m_ovr [NP];
    logic [7:0] m_odp;
    logic [7:0] m_rd;
    logic [LINES-1:0] m_s1, m_s2;

    gpx_regfile #(.NUM_PORTS(NP), .ADDR_W(8), .EXT_BASE(EXT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .drv_str(drv_str),
        .pull_en(pull_en), .pull_up(pull_up)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // 0 hole, 1 in, 2 out, 3 inv, 4 dir, 5 drv lo, 6 drv hi, 7 pull en, 8 pull up, 9 od line, 10 od port
    function automatic int decode(input int a, output int p);
        p = 0;
        for (int b = 0; b < 4; b++)
            for (int q = 0; q < NP; q++)
                if (a == b * S + q) begin p = q; return 1 + b; end
        for (int b = 0; b < 5; b++)
            for (int q = 0; q < NP; q++)
                if (a == EXT + b * S + q) begin p = q; return 5 + b; end
        if (a == EXT + 5 * S) return 10;
        return 0;
    endfunction

    function automatic logic [7:0] model_read(input int k, input int p);
        case (k)
            1: return m_s2[p*8 +: 8] ^ m_inv[p];
            2: return m_out[p];
            3: return m_inv[p];
            4: return m_dir[p];
            5: return m_dlo[p];
            6: return m_dhi[p];
            7: return m_pen[p];
            8: return m_pup[p];
            9: return m_ovr[p];
            10: return m_odp;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int k, p;
        if (!rst_n) begin
            for (int q = 0; q < NP; q++) begin
                m_out[q] = 8'hFF; m_inv[q] = 8'h00; m_dir[q] = 8'hFF;
                m_dlo[q] = 8'hFF; m_dhi[q] = 8'hFF; m_pen[q] = 8'h00;
                m_pup[q] = 8'h00; m_ovr[q] = 8'h00;
            end
            m_odp = 8'h00; m_rd = 8'h00; m_s1 = '0; m_s2 = '0;
        end else begin
            k = decode(int'(bus_addr), p);
            if (bus_valid && !bus_write) m_rd = model_read(k, p);
            if (bus_valid && bus_write) begin
                case (k)
                    2: m_out[p] = bus_wdata;
                    3: m_inv[p] = bus_wdata;
                    4: m_dir[p] = bus_wdata;
                    5: m_dlo[p] = bus_wdata;
                    6: m_dhi[p] = bus_wdata;
                    7: m_pen[p] = bus_wdata;
                    8: m_pup[p] = bus_wdata;
                    9: m_ovr[p] = bus_wdata;
                    10: m_odp = bus_wdata & 8'((1 << NP) - 1);
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        logic [LINES-1:0] e_oe, e_out, e_pen, e_pup;
        logic [2*LINES-1:0] e_drv;
        if (rst_n && !done) begin
            for (int i = 0; i < LINES; i++) begin
                int p, b;
                logic d, o, od;
                p = i / 8; b = i % 8;
                d = m_dir[p][b]; o = m_out[p][b];
                od = m_odp[p] ^ m_ovr[p][b];
                e_oe[i]  = !d && (!od || !o);
                e_out[i] = !d && !od && o;
                e_pen[i] = m_pen[p][b];
                e_pup[i] = m_pup[p][b];
                if (b < 4) e_drv[2*i +: 2] = m_dlo[p][2*b +: 2];
                else       e_drv[2*i +: 2] = m_dhi[p][2*(b-4) +: 2];
            end
            vectors++;
            if (bus_rdata !== m_rd) begin
                miscompares++;
                $display("FAIL R2 R3 R4 R10 rdata: actual %h expected %h", bus_rdata, m_rd);
            end
            if (pad_oe !== e_oe || pad_out !== e_out) begin
                miscompares++;
                $display("FAIL R5 R6 R7 pads: actual oe %h out %h expected oe %h out %h",
                         pad_oe, pad_out, e_oe, e_out);
            end
            if (drv_str !== e_drv) begin
                miscompares++;
                $display("FAIL R8 drv_str: actual %h expected %h", drv_str, e_drv);
            end
            if (pull_en !== e_pen || pull_up !== e_pup) begin
                miscompares++;
                $display("FAIL R9 pulls: actual %h/%h expected %h/%h", pull_en, pull_up, e_pen, e_pup);
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input bit w, input int a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = w; bus_addr = 8'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int a, input logic [7:0] exp);
        op(1'b0, a, 8'h00);
        @(negedge clk);
        check(tag, 64'(bus_rdata), 64'(exp));
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe after reset", 64'(pad_oe), 64'(0));
        check("R1 rdata after reset", 64'(bus_rdata), 64'(0));
        check("R8 drv reset", 64'(drv_str), 64'({2*LINES{1'b1}}));
        check("R9 pull reset", 64'({pull_en, pull_up}), 64'(0));
        @(posedge clk); #1;
        read_chk("R1 R2 direction port0", 3*S, 8'hFF);
        read_chk("R1 R2 output port2", S + 2, 8'hFF);
        // R3 holes
        read_chk("R3 hole read", 3, 8'h00);
        op(1'b1, 3, 8'hAA);
        read_chk("R3 hole after write", 3, 8'h00);
        // R2 full sweep of the map
        for (int a = 0; a < 96; a++) op(1'b1, a, 8'(a * 37 + 5));
        for (int a = 0; a < 96; a++) op(1'b0, a, 8'h00);
        // back to a known state
        rst_n = 1'b0; #1; rst_n = 1'b1;
        @(posedge clk); #1;
        // R4 input with invert, and ignored writes
        pad_in = 24'h123456;
        repeat (3) @(posedge clk); #1;
        op(1'b1, 2*S, 8'h0F);
        read_chk("R4 input xor invert", 0, 8'h56 ^ 8'h0F);
        op(1'b1, 1, 8'h00);
        read_chk("R4 input write ignored", 1, 8'h34);
        // R6 push-pull
        op(1'b1, S, 8'h5A);
        op(1'b1, 3*S, 8'h00);
        @(negedge clk);
        check("R6 push-pull oe", 64'(pad_oe[7:0]), 64'(8'hFF));
        check("R6 push-pull out", 64'(pad_out[7:0]), 64'(8'h5A));
        check("R5 other ports released", 64'(pad_oe[23:8]), 64'(0));
        @(posedge clk); #1;
        // R7 open drain per port then per-line override
        op(1'b1, EXT + 5*S, 8'h01);
        @(negedge clk);
        check("R7 open-drain oe", 64'(pad_oe[7:0]), 64'(8'hA5));
        check("R7 open-drain out", 64'(pad_out[7:0]), 64'(8'h00));
        @(posedge clk); #1;
        op(1'b1, EXT + 4*S, 8'h0F);
        @(negedge clk);
        check("R7 override oe", 64'(pad_oe[7:0]), 64'(8'hAF));
        check("R7 override out", 64'(pad_out[7:0]), 64'(8'h0A));
        @(posedge clk); #1;
        // R8 drive strength field placement
        op(1'b1, EXT, 8'h1B);
        @(negedge clk);
        check("R8 drive fields", 64'(drv_str[7:0]), 64'(8'h1B));
        @(posedge clk); #1;
        // R9 pulls
        op(1'b1, EXT + 2*S, 8'h33);
        op(1'b1, EXT + 3*S, 8'hCC);
        @(negedge clk);
        check("R9 pull enable", 64'(pull_en[7:0]), 64'(8'h33));
        check("R9 pull up", 64'(pull_up[7:0]), 64'(8'hCC));
        @(posedge clk); #1;
        // R10 hold
        read_chk("R10 read value", EXT + 2*S, 8'h33);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 rdata held", 64'(bus_rdata), 64'(8'h33));
        @(posedge clk); #1;
        // random traffic with pad activity against the model
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 3) == 0) pad_in = LINES'($urandom());
            bus_valid = ($urandom_range(0, 3) != 0);
            bus_write = $urandom_range(0, 1) == 1;
            bus_addr  = ($urandom_range(0, 2) == 0) ? 8'($urandom_range(0, 3*S + NP))
                                                    : 8'($urandom_range(0, 95));
            bus_wdata = 8'($urandom());
            @(posedge clk); #1;
        end
        bus_valid = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule